// File: doc/BRIEF.md
# Guarded Software Random-Word Read Port

This block sits between a FIFO of generated random words and the register that software reads them from. A software read strobe pops one word from the FIFO and returns it on the following cycle. Readability is gated by two independent multi-bit enable encodings. The first is a one-time-programmed 8-bit enable. The second is a 4-bit control field. Only the exact "true" encodings open the path, and any other value returns zeros without touching the FIFO. A second read path, for an internal-state word, is gated in the same way by the same one-time-programmed enable and its own 4-bit control field.

Every word actually popped for software is compared with the previously popped word. Two identical consecutive words point to a stuck or faulty bus. When that happens, a sticky bit in a small status register is set. A recoverable alert is driven for as long as any status bit is set. Software clears the status bit by writing a one to it.

Top module: `swrd_guard`

## Requirements
- R1: After reset, rd_data_o, rd_ack_o, st_data_o, st_ack_o, sts_o and alert_o are all zero.
- R2: When the genbits path is enabled, a rd_req_i cycle with fifo_valid_i high drives fifo_pop_o high in that same cycle. fifo_data_i then appears on rd_data_o on the next cycle. rd_ack_o is high on the cycle after every rd_req_i, whatever the data.
- R3: The genbits path is enabled only when otp_en_i equals 8'h96 and gen_ctl_i equals 4'h6. With any other value, a read returns zero and fifo_pop_o stays low.
- R4: A read while fifo_valid_i is low returns zero, does not pop, and leaves the previously popped word unchanged as the reference for the next comparison.
- R5: A popped word equal to the previously popped word sets status bit 0 (sts_o[0]) on the cycle after the read.
- R6: The first word popped after reset is never flagged as a repeat.
- R7: alert_o is high exactly when sts_o is non-zero.
- R8: The status register is write-1-to-clear. A sts_wr_i cycle clears each bit whose sts_wdata_i bit is 1, and bits written as 0 are kept. A repeat detected in the same cycle as a clear of bit 0 wins, so the bit stays set.
- R9: A st_req_i cycle returns st_data_i on st_data_o on the next cycle only when otp_en_i equals 8'h96 and st_ctl_i equals 4'h6. Otherwise it returns zero. st_ack_o is high on the cycle after every st_req_i.
- R10: Status bits 3..1 are never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| otp_en_i | input | 8 | One-time-programmed read enable, multi-bit encoded |
| gen_ctl_i | input | 4 | Control enable for the random-word path, multi-bit encoded |
| st_ctl_i | input | 4 | Control enable for the internal-state path, multi-bit encoded |
| fifo_valid_i | input | 1 | FIFO holds a word |
| fifo_data_i | input | 32 | Word at the head of the FIFO |
| fifo_pop_o | output | 1 | Pop the FIFO head this cycle |
| rd_req_i | input | 1 | Software read strobe for the random-word register |
| rd_data_o | output | 32 | Random-word read result |
| rd_ack_o | output | 1 | Random-word read result valid |
| st_req_i | input | 1 | Software read strobe for the internal-state register |
| st_data_i | input | 32 | Internal-state word to expose |
| st_data_o | output | 32 | Internal-state read result |
| st_ack_o | output | 1 | Internal-state read result valid |
| sts_wr_i | input | 1 | Status register write strobe |
| sts_wdata_i | input | 4 | Status write data, ones clear bits |
| sts_o | output | 4 | Recoverable-alert status register |
| alert_o | output | 1 | Recoverable alert request |

## Verification
The assertions watch several properties on every cycle. A pop never happens unless both enables carry their true encodings and data is present. A locked read always yields zero. The alert matches the status register. The reserved status bits stay low, and a set status bit holds until it is cleared. A checker-side copy of the last popped word also lets them catch a missed or spurious repeat flag, including on the first pop after reset. Other behaviours need scenarios from the bench to show them. These are an empty read that leaves the comparison reference untouched, set taking priority over a same-cycle clear, and a write of zero having no effect.

// File: rtl/swrd_pkg.sv
package swrd_pkg;

    localparam int          MB8_W    = 8;
    localparam int          MB4_W    = 4;
    localparam logic [7:0]  MB8_TRUE = 8'h96;
    localparam logic [3:0]  MB4_TRUE = 4'h6;

    // Status register layout
    localparam int STS_W      = 4;
    localparam int REPEAT_BIT = 0;

endpackage

// File: rtl/swrd_mubi_gate.sv
// Opens a path only when every multi-bit enable input carries its exact true code.
module swrd_mubi_gate #(
    parameter int          NUM_EN = 2,
    parameter int          W      = 4,
    parameter logic [W-1:0] TRUE_VAL = '0
) (
    input  logic [NUM_EN-1:0][W-1:0] code_i,
    output logic                     open_o
);
    logic [NUM_EN-1:0] match;

    for (genvar g = 0; g < NUM_EN; g++) begin : g_match
        assign match[g] = (code_i[g] == TRUE_VAL);
    end

    assign open_o = &match;
endmodule

// File: rtl/swrd_repeat_det.sv
// Remembers the last popped word and reports when the next one equals it.
module swrd_repeat_det #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_i,
    input  logic [DW-1:0] word_i,
    output logic          repeat_o
);
    typedef struct packed {
        logic [DW-1:0] prev;
        logic          have;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d    = det_q;
        repeat_o = pop_i && det_q.have && (word_i == det_q.prev);
        if (pop_i) begin
            det_d.prev = word_i;
            det_d.have = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end
endmodule

// File: rtl/swrd_alert_sts.sv
// Sticky write-1-to-clear status; a set in the same cycle beats a clear.
module swrd_alert_sts #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] sts_o,
    output logic         alert_o
);
    logic [W-1:0] sts_d, sts_q;
    logic [W-1:0] clr_mask;

    always_comb begin
        clr_mask = wr_i ? wdata_i : '0;
        sts_d    = (sts_q & ~clr_mask) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign sts_o   = sts_q;
    assign alert_o = |sts_q;
endmodule

// File: rtl/swrd_guard.sv
module swrd_guard
    import swrd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MB8_W-1:0]  otp_en_i,
    input  logic [MB4_W-1:0]  gen_ctl_i,
    input  logic [MB4_W-1:0]  st_ctl_i,
    input  logic              fifo_valid_i,
    input  logic [DW-1:0]     fifo_data_i,
    output logic              fifo_pop_o,
    input  logic              rd_req_i,
    output logic [DW-1:0]     rd_data_o,
    output logic              rd_ack_o,
    input  logic              st_req_i,
    input  logic [DW-1:0]     st_data_i,
    output logic [DW-1:0]     st_data_o,
    output logic              st_ack_o,
    input  logic              sts_wr_i,
    input  logic [STS_W-1:0]  sts_wdata_i,
    output logic [STS_W-1:0]  sts_o,
    output logic              alert_o
);
    typedef struct packed {
        logic [DW-1:0] rd_data;
        logic          rd_ack;
        logic [DW-1:0] st_data;
        logic          st_ack;
    } port_t;

    port_t r_d, r_q;

    logic otp_open;
    logic gen_open;
    logic st_open;
    logic pop;
    logic rep_hit;
    logic [STS_W-1:0] sts_set;

    swrd_mubi_gate #(.NUM_EN(1), .W(MB8_W), .TRUE_VAL(MB8_TRUE)) u_otp_gate (
        .code_i (otp_en_i),
        .open_o (otp_open)
    );

    swrd_mubi_gate #(.NUM_EN(1), .W(MB4_W), .TRUE_VAL(MB4_TRUE)) u_gen_gate (
        .code_i (gen_ctl_i),
        .open_o (gen_open)
    );

    swrd_mubi_gate #(.NUM_EN(1), .W(MB4_W), .TRUE_VAL(MB4_TRUE)) u_st_gate (
        .code_i (st_ctl_i),
        .open_o (st_open)
    );

    assign pop = rd_req_i && otp_open && gen_open && fifo_valid_i;

    swrd_repeat_det #(.DW(DW)) u_rep (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_i    (pop),
        .word_i   (fifo_data_i),
        .repeat_o (rep_hit)
    );

    always_comb begin
        sts_set             = '0;
        sts_set[REPEAT_BIT] = rep_hit;
    end

    swrd_alert_sts #(.W(STS_W)) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (sts_set),
        .wr_i    (sts_wr_i),
        .wdata_i (sts_wdata_i),
        .sts_o   (sts_o),
        .alert_o (alert_o)
    );

    always_comb begin
        r_d         = r_q;
        r_d.rd_ack  = rd_req_i;
        r_d.st_ack  = st_req_i;
        if (rd_req_i) r_d.rd_data = pop ? fifo_data_i : '0;
        if (st_req_i) r_d.st_data = (otp_open && st_open) ? st_data_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign fifo_pop_o = pop;
    assign rd_data_o  = r_q.rd_data;
    assign rd_ack_o   = r_q.rd_ack;
    assign st_data_o  = r_q.st_data;
    assign st_ack_o   = r_q.st_ack;
endmodule

// File: rtl/swrd_guard_chk.sv
module swrd_guard_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    otp_en_i,
    input logic [3:0]    gen_ctl_i,
    input logic          fifo_valid_i,
    input logic [DW-1:0] fifo_data_i,
    input logic          fifo_pop_o,
    input logic          rd_req_i,
    input logic [DW-1:0] rd_data_o,
    input logic          rd_ack_o,
    input logic          sts_wr_i,
    input logic [3:0]    sts_wdata_i,
    input logic [3:0]    sts_o,
    input logic          alert_o
);
    logic          seen_q;
    logic [DW-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (fifo_pop_o) begin
            seen_q <= 1'b1;
            last_q <= fifo_data_i;
        end
    end

    p_pop_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> (rd_req_i && fifo_valid_i && otp_en_i == 8'h96 && gen_ctl_i == 4'h6));

    p_locked_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && (otp_en_i != 8'h96 || gen_ctl_i != 4'h6)) |=> (rd_data_o == '0));

    p_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |=> rd_ack_o);

    p_repeat_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop_o && seen_q && fifo_data_i == last_q) |=> sts_o[0]);

    p_first_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop_o && !seen_q && !sts_o[0]) |=> !sts_o[0]);

    p_alert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alert_o == (sts_o != 4'b0));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o[0] && !(sts_wr_i && sts_wdata_i[0])) |=> sts_o[0]);

    p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sts_o[3:1] == 3'b0);
endmodule

bind swrd_guard swrd_guard_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .otp_en_i     (otp_en_i),
    .gen_ctl_i    (gen_ctl_i),
    .fifo_valid_i (fifo_valid_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_pop_o   (fifo_pop_o),
    .rd_req_i     (rd_req_i),
    .rd_data_o    (rd_data_o),
    .rd_ack_o     (rd_ack_o),
    .sts_wr_i     (sts_wr_i),
    .sts_wdata_i  (sts_wdata_i),
    .sts_o        (sts_o),
    .alert_o      (alert_o)
);

// File: tb/swrd_guard_tb.sv
module swrd_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  otp_en_i = '0;
    logic [3:0]  gen_ctl_i = '0;
    logic [3:0]  st_ctl_i = '0;
    logic        fifo_valid_i = 1'b0;
    logic [31:0] fifo_data_i = '0;
    logic        fifo_pop_o;
    logic        rd_req_i = 1'b0;
    logic [31:0] rd_data_o;
    logic        rd_ack_o;
    logic        st_req_i = 1'b0;
    logic [31:0] st_data_i = '0;
    logic [31:0] st_data_o;
    logic        st_ack_o;
    logic        sts_wr_i = 1'b0;
    logic [3:0]  sts_wdata_i = '0;
    logic [3:0]  sts_o;
    logic        alert_o;

    int checks = 0;
    int errors = 0;

    // bench model
    logic        m_have = 1'b0;
    logic [31:0] m_prev = '0;
    logic [3:0]  m_sts  = '0;
    logic [31:0] m_rd   = '0;
    logic        m_rack = 1'b0;
    logic [31:0] m_st   = '0;
    logic        m_sack = 1'b0;

    always #2.5 clk = ~clk;

    swrd_guard u_dut (.*);

    function automatic bit gen_ok(logic [7:0] o, logic [3:0] c);
        return (o == 8'h96) && (c == 4'h6);
    endfunction

    function automatic bit exp_pop(logic req, logic v, logic [7:0] o, logic [3:0] c);
        return req && v && gen_ok(o, c);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, check pop, advance model at posedge, check outputs.
    task automatic step(input logic req, input logic v, input logic [31:0] d,
                        input logic [7:0] o, input logic [3:0] gc,
                        input logic sreq, input logic [3:0] sc, input logic [31:0] sd,
                        input logic wr, input logic [3:0] wd, input string tag);
        bit p;
        bit hit;
        @(negedge clk);
        rd_req_i = req; fifo_valid_i = v; fifo_data_i = d; otp_en_i = o; gen_ctl_i = gc;
        st_req_i = sreq; st_ctl_i = sc; st_data_i = sd; sts_wr_i = wr; sts_wdata_i = wd;
        #1;
        p = exp_pop(req, v, o, gc);
        chk(fifo_pop_o == p, {tag, " R2/R3 pop"}, 32'(fifo_pop_o), 32'(p));
        hit = p && m_have && (d == m_prev);
        if (p) begin m_prev = d; m_have = 1'b1; end
        m_rack = req;
        if (req) m_rd = p ? d : '0;
        m_sack = sreq;
        if (sreq) m_st = ((o == 8'h96) && (sc == 4'h6)) ? sd : '0;
        if (wr) m_sts = m_sts & ~wd;
        if (hit) m_sts[0] = 1'b1;
        @(posedge clk);
        #1;
        chk(rd_ack_o == m_rack, {tag, " R2 ack"}, 32'(rd_ack_o), 32'(m_rack));
        chk(rd_data_o == m_rd, {tag, " R2/R3/R4 data"}, rd_data_o, m_rd);
        chk(st_ack_o == m_sack, {tag, " R9 ack"}, 32'(st_ack_o), 32'(m_sack));
        chk(st_data_o == m_st, {tag, " R9 data"}, st_data_o, m_st);
        chk(sts_o == m_sts, {tag, " R5/R6/R8/R10 sts"}, 32'(sts_o), 32'(m_sts));
        chk(alert_o == (m_sts != 0), {tag, " R7 alert"}, 32'(alert_o), 32'(m_sts != 0));
    endtask

    task automatic rd(input logic v, input logic [31:0] d, input string tag);
        step(1'b1, v, d, 8'h96, 4'h6, 1'b0, 4'h0, 32'h0, 1'b0, 4'h0, tag);
    endtask

    task automatic clr(input logic [3:0] wd, input string tag);
        step(1'b0, 1'b0, 32'h0, 8'h96, 4'h6, 1'b0, 4'h0, 32'h0, 1'b1, wd, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        chk(rd_data_o == 0 && rd_ack_o == 0 && st_data_o == 0 && st_ack_o == 0,
            "R1 reset outputs", rd_data_o, 0);
        chk(sts_o == 0 && alert_o == 0, "R1 reset status", 32'(sts_o), 0);
        @(negedge clk); rst_n = 1'b1;

        // R6: first read after reset, even of zero data, is clean
        rd(1'b1, 32'h0, "R6 first");
        rd(1'b1, 32'h0, "R5 repeat zero");
        clr(4'h0, "R8 write zero keeps");
        clr(4'h1, "R8 write one clears");
        // R4: empty read keeps reference
        rd(1'b1, 32'hA5A5_0001, "R2 pop A");
        rd(1'b0, 32'hA5A5_0001, "R4 empty");
        rd(1'b1, 32'hA5A5_0001, "R4 ref kept repeat");
        // R8: set wins over clear
        step(1'b1, 1'b1, 32'hA5A5_0001, 8'h96, 4'h6, 1'b0, 4'h0, 32'h0, 1'b1, 4'hF, "R8 set beats clear");
        clr(4'hF, "R8 clear all");
        // R3: locked encodings
        step(1'b1, 1'b1, 32'h1234_5678, 8'h69, 4'h6, 1'b0, 4'h0, 32'h0, 1'b0, 4'h0, "R3 otp bad");
        step(1'b1, 1'b1, 32'h1234_5678, 8'h96, 4'h9, 1'b0, 4'h0, 32'h0, 1'b0, 4'h0, "R3 ctl bad");
        // R9: state path
        step(1'b0, 1'b0, 32'h0, 8'h96, 4'h0, 1'b1, 4'h6, 32'hDEAD_BEEF, 1'b0, 4'h0, "R9 open");
        step(1'b0, 1'b0, 32'h0, 8'h00, 4'h0, 1'b1, 4'h6, 32'hDEAD_BEEF, 1'b0, 4'h0, "R9 otp bad");
        step(1'b0, 1'b0, 32'h0, 8'h96, 4'h0, 1'b1, 4'h7, 32'hDEAD_BEEF, 1'b0, 4'h0, "R9 ctl bad");

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  o;
            logic [3:0]  gc;
            logic [3:0]  sc;
            logic [31:0] d;
            o  = ($urandom % 5 != 0) ? 8'h96 : 8'($urandom);
            gc = ($urandom % 5 != 0) ? 4'h6 : 4'($urandom);
            sc = ($urandom % 3 != 0) ? 4'h6 : 4'($urandom);
            d  = ($urandom % 3 == 0) ? 32'($urandom % 3) : $urandom;
            step(1'($urandom % 4 != 0), 1'($urandom % 5 != 0), d, o, gc,
                 1'($urandom % 2), sc, $urandom,
                 1'($urandom % 6 == 0), 4'($urandom), "rand");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule